// File: doc/BRIEF.md
# Sample Fetch Address Generator

This block supplies the memory address for each byte fetched by a sample-playback channel, and tracks how many bytes of the current sample remain. A start strobe captures an 8-bit start value and an 8-bit length value. From these it forms a first address on a 64-byte boundary in the upper quarter of the address space, and a byte count of sixteen times the length plus one.

Each fetch-done strobe moves the address forward by one and takes one from the count. The address register holds only the low 15 bits, and the top address bit is always 1. Because of this, stepping past the last address lands on 0x8000 rather than on zero. When the final byte has been fetched, the block pulses an end-of-sample output for one cycle. If the loop input is high at that moment, the block reloads the address and count from the values it captured at the last start, and playback continues without a gap.

Top module: `sfa_fetch_addr_gen`

## Requirements
- R1: After reset the address output reads 0xC000, the remaining count reads 0 and the end output is low.
- R2: The cycle after a start strobe, the address reads 0xC000 + 64 × start value (bits 15 and 14 set, bits 13..6 from the start value, bits 5..0 zero).
- R3: The cycle after a start strobe, the remaining count reads 16 × length value + 1.
- R4: A fetch-done strobe while the remaining count is above 1 makes the address one higher and the count one lower in the next cycle.
- R5: Address bit 15 is always 1, and stepping the address from 0xFFFF gives 0x8000.
- R6: A fetch-done strobe while the remaining count is 0 and no start is present leaves the address and the count unchanged.
- R7: The fetch-done strobe that takes the count from 1 to 0 with loop low raises the end output for exactly the next cycle; the count then reads 0 and the address has stepped by one.
- R8: With loop high, that last fetch-done strobe still pulses the end output, and it reloads the address and count from the start and length values captured at the last start strobe, not from the current inputs.
- R9: When start and fetch-done arrive in the same cycle, the start wins, and the result is as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sample from the start and length values |
| start_val | input | 8 | Start value: address bits 13..6 |
| len_val | input | 8 | Length value, in units of 16 bytes |
| loop_en | input | 1 | Restart automatically when the sample ends |
| fetch_done | input | 1 | One sample byte has been fetched |
| addr | output | 16 | Address of the next byte to fetch |
| remaining | output | 12 | Bytes still to fetch in this sample |
| end_o | output | 1 | One-cycle pulse after the last byte is fetched |

## Verification
A corrupted address register shows on the address port in the very next cycle. The address is compared against the model on every clock, so a bad increment, a wrong wrap or a lost bit is caught at once. A wrong count may go unseen while the address still steps correctly. It does show on the count port every cycle, and it also shows as an end pulse arriving early or late. A stale or live-input reload shows only at a loop boundary, so a loop case is run in which the inputs change after the start strobe.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  // Operation applied to both counters in a given cycle
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
  import sfa_pkg::*;
#(
  parameter int START_W = 8,
  parameter int LEN_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [START_W-1:0] start_val,
  input  logic [LEN_W-1:0]   len_val,
  input  logic               loop_en,
  input  logic               fetch_done,
  input  logic               cnt_zero,
  input  logic               cnt_one,
  output ctr_op_e            op,
  output logic [START_W-1:0] ld_start,
  output logic [LEN_W-1:0]   ld_len,
  output logic               end_o
);
  logic [START_W-1:0] snap_start;
  logic [LEN_W-1:0]   snap_len;
  logic               last_fetch;
  logic               reload;

  // The fetch that consumes the final byte of the sample
  assign last_fetch = !start && fetch_done && cnt_one;
  assign reload     = last_fetch && loop_en;

  always_comb begin
    if (start) begin
      op = OP_LOAD;
    end else if (reload) begin
      op = OP_LOAD;
    end else if (fetch_done && !cnt_zero) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end
  end

  // A start loads the live inputs; a loop reload uses the captured copies
  assign ld_start = start ? start_val : snap_start;
  assign ld_len   = start ? len_val   : snap_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_start <= '0;
      snap_len   <= '0;
      end_o      <= 1'b0;
    end else begin
      if (start) begin
        snap_start <= start_val;
        snap_len   <= len_val;
      end
      end_o <= last_fetch;
    end
  end
endmodule

// File: rtl/sfa_addr_ctr.sv
module sfa_addr_ctr
  import sfa_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int START_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctr_op_e            op,
  input  logic [START_W-1:0] ld_start,
  output logic [ADDR_W-1:0]  addr
);
  // Only the bits below the top address bit are stored
  localparam int REG_W = ADDR_W - 1;
  localparam int LOW_W = REG_W - 1 - START_W;

  logic [REG_W-1:0] addr_q;
  logic [REG_W-1:0] load_val;

  assign load_val = {1'b1, ld_start, {LOW_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= {1'b1, {(REG_W-1){1'b0}}};
    end else begin
      case (op)
        OP_LOAD: addr_q <= load_val;
        OP_STEP: addr_q <= addr_q + 1'b1;
        default: addr_q <= addr_q;
      endcase
    end
  end

  // Top bit tied high, so the 15-bit wrap lands at the middle of memory
  assign addr = {1'b1, addr_q};
endmodule

// File: rtl/sfa_len_ctr.sv
module sfa_len_ctr
  import sfa_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int LEN_SHIFT = 4,
  parameter int CNT_W     = LEN_W + LEN_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  ctr_op_e          op,
  input  logic [LEN_W-1:0] ld_len,
  output logic [CNT_W-1:0] remaining,
  output logic             cnt_zero,
  output logic             cnt_one
);
  logic [CNT_W-1:0] load_val;

  // 16 x length + 1; the low bits are zero so the +1 never carries
  assign load_val = {ld_len, {(LEN_SHIFT-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else begin
      case (op)
        OP_LOAD: remaining <= load_val;
        OP_STEP: remaining <= remaining - 1'b1;
        default: remaining <= remaining;
      endcase
    end
  end

  assign cnt_zero = (remaining == '0);
  assign cnt_one  = (remaining == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/sfa_fetch_addr_gen.sv
module sfa_fetch_addr_gen
  import sfa_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int START_W   = 8,
  parameter int LEN_W     = 8,
  parameter int LEN_SHIFT = 4,
  parameter int CNT_W     = LEN_W + LEN_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [START_W-1:0] start_val,
  input  logic [LEN_W-1:0]   len_val,
  input  logic               loop_en,
  input  logic               fetch_done,
  output logic [ADDR_W-1:0]  addr,
  output logic [CNT_W-1:0]   remaining,
  output logic               end_o
);
  ctr_op_e            op;
  logic [START_W-1:0] ld_start;
  logic [LEN_W-1:0]   ld_len;
  logic               cnt_zero;
  logic               cnt_one;

  sfa_ctrl #(.START_W(START_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_val  (start_val),
    .len_val    (len_val),
    .loop_en    (loop_en),
    .fetch_done (fetch_done),
    .cnt_zero   (cnt_zero),
    .cnt_one    (cnt_one),
    .op         (op),
    .ld_start   (ld_start),
    .ld_len     (ld_len),
    .end_o      (end_o)
  );

  sfa_addr_ctr #(.ADDR_W(ADDR_W), .START_W(START_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ld_start (ld_start),
    .addr     (addr)
  );

  sfa_len_ctr #(.LEN_W(LEN_W), .LEN_SHIFT(LEN_SHIFT), .CNT_W(CNT_W)) u_len (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .ld_len    (ld_len),
    .remaining (remaining),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one)
  );
endmodule

// File: rtl/sfa_fetch_addr_gen_chk.sv
module sfa_fetch_addr_gen_chk #(
  parameter int ADDR_W    = 16,
  parameter int START_W   = 8,
  parameter int LEN_W     = 8,
  parameter int LEN_SHIFT = 4,
  parameter int CNT_W     = LEN_W + LEN_SHIFT
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [START_W-1:0] start_val,
  input logic [LEN_W-1:0]   len_val,
  input logic               loop_en,
  input logic               fetch_done,
  input logic [ADDR_W-1:0]  addr,
  input logic [CNT_W-1:0]   remaining,
  input logic               end_o
);
  localparam int LOW_W = ADDR_W - 2 - START_W;

  // R2: start address formed from the start value
  a_r2_start_addr: assert property (@(posedge clk) disable iff (rst)
    start |=> addr == {2'b11, $past(start_val), {LOW_W{1'b0}}});

  // R3: byte count formed from the length value
  a_r3_start_count: assert property (@(posedge clk) disable iff (rst)
    start |=> remaining == CNT_W'(({{LEN_SHIFT{1'b0}}, $past(len_val)} << LEN_SHIFT) + 1));

  // R4 and R5: a step moves the address by one inside the upper half
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!start && fetch_done && remaining > 1) |=>
      (addr == {1'b1, $past(addr[ADDR_W-2:0]) + 1'b1}) && (remaining == $past(remaining) - 1'b1));

  // R6: a fetch with nothing left changes nothing
  a_r6_idle_fetch: assert property (@(posedge clk) disable iff (rst)
    (!start && fetch_done && remaining == '0) |=> $stable(addr) && $stable(remaining));

  // R7: the last byte raises the end pulse
  a_r7_end_pulse: assert property (@(posedge clk) disable iff (rst)
    (!start && fetch_done && remaining == 1) |=> end_o);

  // R7: no end pulse without a final fetch
  a_r7_no_spurious_end: assert property (@(posedge clk) disable iff (rst)
    !(!start && fetch_done && remaining == 1) |=> !end_o);
endmodule

bind sfa_fetch_addr_gen sfa_fetch_addr_gen_chk #(
  .ADDR_W(ADDR_W), .START_W(START_W), .LEN_W(LEN_W),
  .LEN_SHIFT(LEN_SHIFT), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .start_val  (start_val),
  .len_val    (len_val),
  .loop_en    (loop_en),
  .fetch_done (fetch_done),
  .addr       (addr),
  .remaining  (remaining),
  .end_o      (end_o)
);

// File: tb/sfa_fetch_addr_gen_test.sv
module sfa_fetch_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  start_val = '0;
  logic [7:0]  len_val = '0;
  logic        loop_en = 1'b0;
  logic        fetch_done = 1'b0;
  logic [15:0] addr;
  logic [11:0] remaining;
  logic        end_o;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit armed = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_reg, m_rem, s_val, s_len;
  bit m_end;

  always #4 clk = ~clk;

  sfa_fetch_addr_gen uut (
    .clk(clk), .rst(rst), .start(start), .start_val(start_val),
    .len_val(len_val), .loop_en(loop_en), .fetch_done(fetch_done),
    .addr(addr), .remaining(remaining), .end_o(end_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_reg = 16384; m_rem = 0; m_end = 0; s_val = 0; s_len = 0;
    end else begin
      m_end = 0;
      if (start) begin
        m_reg = 16384 + 64 * start_val;
        m_rem = 16 * len_val + 1;
        s_val = start_val; s_len = len_val;
      end else if (fetch_done && m_rem > 0) begin
        if (m_rem == 1) begin
          m_end = 1;
          if (loop_en) begin
            m_reg = 16384 + 64 * s_val;
            m_rem = 16 * s_len + 1;
          end else begin
            m_reg = (m_reg + 1) % 32768;
            m_rem = 0;
          end
        end else begin
          m_reg = (m_reg + 1) % 32768;
          m_rem = m_rem - 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      chk(cur_req, "addr", int'(addr), 32768 + m_reg);
      chk(cur_req, "remaining", int'(remaining), m_rem);
      chk(cur_req, "end", int'(end_o), int'(m_end));
    end
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic do_start(input logic [7:0] v, input logic [7:0] l, input logic lp);
    @(negedge clk);
    start = 1'b1; start_val = v; len_val = l; loop_en = lp; fetch_done = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic fetch(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      fetch_done = 1'b1;
      @(negedge clk);
      fetch_done = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    armed = 1'b1;
    cur_req = "R1";
    chk("R1", "reset addr", int'(addr), 'hC000);
    chk("R1", "reset remaining", int'(remaining), 0);
    chk("R1", "reset end", int'(end_o), 0);

    cur_req = "R2";
    do_start(8'h12, 8'd2, 1'b0);
    chk("R2", "start addr", int'(addr), 'hC480);
    chk("R3", "start count", int'(remaining), 33);

    cur_req = "R4";
    fetch(5, 0);
    chk("R4", "step addr", int'(addr), 'hC485);
    chk("R4", "step count", int'(remaining), 28);
    fetch(4, 2);
    cur_req = "R7";
    fetch(23, 0);
    chk("R7", "pre-end count", int'(remaining), 1);
    fetch(1, 0);
    chk("R7", "end pulse", int'(end_o), 1);
    chk("R7", "end count", int'(remaining), 0);
    chk("R7", "end addr", int'(addr), 'hC4A1);
    @(negedge clk);
    chk("R7", "end pulse width", int'(end_o), 0);

    cur_req = "R6";
    fetch(3, 0);
    chk("R6", "idle addr", int'(addr), 'hC4A1);
    chk("R6", "idle count", int'(remaining), 0);

    cur_req = "R5";
    do_start(8'hFF, 8'd4, 1'b0);
    chk("R5", "top start addr", int'(addr), 'hFFC0);
    fetch(63, 0);
    chk("R5", "last addr", int'(addr), 'hFFFF);
    fetch(1, 0);
    chk("R5", "wrap addr", int'(addr), 'h8000);
    fetch(2, 1);

    cur_req = "R8";
    do_start(8'h03, 8'd0, 1'b1);
    start_val = 8'h77; len_val = 8'd9;
    fetch(1, 0);
    chk("R8", "loop end pulse", int'(end_o), 1);
    chk("R8", "loop reload addr", int'(addr), 'hC0C0);
    chk("R8", "loop reload count", int'(remaining), 1);
    fetch(1, 1);
    chk("R8", "loop again addr", int'(addr), 'hC0C0);

    cur_req = "R9";
    loop_en = 1'b0;
    @(negedge clk);
    start = 1'b1; fetch_done = 1'b1; start_val = 8'h20; len_val = 8'd1;
    @(negedge clk);
    start = 1'b0; fetch_done = 1'b0;
    chk("R9", "priority addr", int'(addr), 'hC800);
    chk("R9", "priority count", int'(remaining), 17);
    fetch(17, 0);
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule